// File: doc/BRIEF.md
# Expansion Slot ROM Ownership Arbiter

This block arbitrates the peripheral ROM window at 0xC100–0xCFFF. For every strobed access it decides what drives the data: the internal system ROM, the ROM page of one of seven slot cards, or the shared 2 KB expansion ROM of one card. Each card has a 256-byte page at 0xCn00–0xCnFF. The shared area at 0xC800–0xCFFF belongs to one card at a time.

Ownership of the shared area is a side effect of the access stream. Touching a card's page gives that card the shared area. An access to 0xCFFF releases it. When slot 3 is mapped to internal ROM, an access there sets a hidden flag. While that flag is set, the shared area also reads from internal ROM. Two level flags come from elsewhere in the system: `slot3_rom_i` (slot 3 card ROM enabled) and `int_cx_i` (whole window forced internal).

The source select is combinational from the current address and the stored state. State changes on the clock edge that ends a strobed access.

Top module: `slot_rom_arbiter`

## Requirements
- R1: `src_o` encodes 0 = none, 1 = internal ROM, 2 = card page ROM, 3 = expansion ROM. The slot number of an access is address bits [11:8]. Address bits [15:12] must be 0xC, and slot 0 (0xC000–0xC0FF) is outside the window. A strobed access to a card page 0xCn00–0xCnFF (n = 1..7) that no higher rule claims gives `src_o`=2 and `slot_o`=n.
- R2: With `slot3_rom_i`=0, a strobed access in 0xC300–0xC3FF gives `src_o`=1 and sets the hidden internal-expansion flag. This applies whatever the value of `int_cx_i`.
- R3: With `int_cx_i`=1, every other strobed window access, including 0xCFFF, gives `src_o`=1. Such an access leaves both the owner and the hidden flag unchanged.
- R4: A strobed card-page access under R1 records that slot as owner and clears the hidden flag. Later expansion accesses then give `src_o`=3 and `slot_o` = owner.
- R5: A strobed access to 0xCFFF, when R3 does not apply, gives `src_o`=3 and `slot_o`=0 on that same access. This holds even if the hidden flag was set. The access clears both the owner and the hidden flag.
- R6: While the hidden flag is set, strobed accesses in 0xC800–0xCFFE give `src_o`=1.
- R7: The active-low asynchronous reset clears the owner to 0 and clears the hidden flag.
- R8: With `strobe_i` low, or with an address outside the window, `src_o`=0 and `slot_o`=0, and no state changes.
- R9: State updates made by an access become visible to the next access after the clock edge. The access that makes them selects its source using the state from before the update.
- R10: `slot_o` is 0 whenever `src_o` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Access address |
| strobe_i | input | 1 | Valid access this cycle |
| slot3_rom_i | input | 1 | Slot 3 card ROM enabled |
| int_cx_i | input | 1 | Force whole window to internal ROM |
| src_o | output | 2 | Data source select |
| slot_o | output | 3 | Slot number for card or expansion source |

## Verification
`src_o` and `slot_o` are combinational, so they are due in the same cycle the address and strobe are applied. The bench drives inputs on the falling edge and samples two nanoseconds later. Ownership and hidden-flag changes are due one rising edge after the strobed access. Each check of a stored effect is therefore made by a probe access on the following falling edge, through the expansion window. That probe also shows that the access making the change still selected its source from the old state.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_INT  = 2'd1,
    SRC_CARD = 2'd2,
    SRC_EXP  = 2'd3
  } rom_src_e;
endpackage

// File: rtl/slot_addr_decode.sv
module slot_addr_decode #(
  parameter int ADDR_W   = 16,
  parameter int SLOT_W   = 3,
  parameter int PAGE_LSB = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_win_o,
  output logic              card_pg_o,
  output logic              rel_o,
  output logic [SLOT_W-1:0] page_slot_o
);
  localparam int PAGE_W = SLOT_W + 1;
  localparam int HI_LSB = PAGE_LSB + PAGE_W;
  localparam int HI_W   = ADDR_W - HI_LSB;
  localparam logic [HI_W-1:0]   WIN_HI  = HI_W'(12);
  localparam logic [HI_LSB-1:0] REL_LOW = '1;

  logic [PAGE_W-1:0] page;

  assign page        = addr_i[PAGE_LSB +: PAGE_W];
  assign in_win_o    = (addr_i[ADDR_W-1:HI_LSB] == WIN_HI) && (page != '0);
  assign card_pg_o   = in_win_o && !page[PAGE_W-1];
  assign rel_o       = in_win_o && (addr_i[HI_LSB-1:0] == REL_LOW);
  assign page_slot_o = page[SLOT_W-1:0];
endmodule

// File: rtl/slot_owner_track.sv
module slot_owner_track #(
  parameter int SLOT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              s3_path_i,
  input  logic              int_cx_i,
  input  logic              card_pg_i,
  input  logic              rel_i,
  input  logic [SLOT_W-1:0] page_slot_i,
  output logic [SLOT_W-1:0] owner_o,
  output logic              int_exp_o
);
  logic [SLOT_W-1:0] owner_q, owner_d;
  logic              int_exp_q, int_exp_d;

  always_comb begin
    owner_d   = owner_q;
    int_exp_d = int_exp_q;
    if (strobe_i) begin
      if (s3_path_i) begin
        int_exp_d = 1'b1;
      end else if (int_cx_i) begin
        // forced internal: state untouched
      end else if (card_pg_i) begin
        owner_d   = page_slot_i;
        int_exp_d = 1'b0;
      end else if (rel_i) begin
        owner_d   = '0;
        int_exp_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q   <= '0;
      int_exp_q <= 1'b0;
    end else begin
      owner_q   <= owner_d;
      int_exp_q <= int_exp_d;
    end
  end

  assign owner_o   = owner_q;
  assign int_exp_o = int_exp_q;

  a_r4_claim_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && card_pg_i && !s3_path_i && !int_cx_i) |=> (owner_q == $past(page_slot_i)) && !int_exp_q);
  a_r2_hidden_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && s3_path_i) |=> int_exp_q);
  a_r3_cx_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && int_cx_i && !s3_path_i) |=> $stable(owner_q) && $stable(int_exp_q));
  a_r5_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && rel_i && !int_cx_i) |=> (owner_q == '0) && !int_exp_q);
  a_r8_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(owner_q) && $stable(int_exp_q));
endmodule

// File: rtl/slot_src_sel.sv
module slot_src_sel
  import slot_arb_pkg::*;
#(
  parameter int SLOT_W = 3
) (
  input  logic              strobe_i,
  input  logic              in_win_i,
  input  logic              card_pg_i,
  input  logic              rel_i,
  input  logic              s3_path_i,
  input  logic              int_cx_i,
  input  logic [SLOT_W-1:0] page_slot_i,
  input  logic [SLOT_W-1:0] owner_i,
  input  logic              int_exp_i,
  output rom_src_e          src_o,
  output logic [SLOT_W-1:0] slot_o
);
  always_comb begin
    src_o  = SRC_NONE;
    slot_o = '0;
    if (strobe_i && in_win_i) begin
      if (s3_path_i || int_cx_i) begin
        src_o = SRC_INT;
      end else if (card_pg_i) begin
        src_o  = SRC_CARD;
        slot_o = page_slot_i;
      end else if (rel_i) begin
        // release takes effect on this access
        src_o = SRC_EXP;
      end else if (int_exp_i) begin
        src_o = SRC_INT;
      end else begin
        src_o  = SRC_EXP;
        slot_o = owner_i;
      end
    end
  end

  always_comb begin
    a_r10_slot_zero: assert ((src_o != SRC_NONE && src_o != SRC_INT) || slot_o == '0);
  end
endmodule

// File: rtl/slot_rom_arbiter.sv
module slot_rom_arbiter
  import slot_arb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SLOT_W   = 3,
  parameter int INT_SLOT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_i,
  input  logic              slot3_rom_i,
  input  logic              int_cx_i,
  output logic [1:0]        src_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] INT_SLOT_ID = SLOT_W'(INT_SLOT);

  logic              in_win, card_pg, rel, s3_path, int_exp;
  logic [SLOT_W-1:0] page_slot, owner;
  rom_src_e          src;

  slot_addr_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .PAGE_LSB(8)) i_dec (
    .addr_i     (addr_i),
    .in_win_o   (in_win),
    .card_pg_o  (card_pg),
    .rel_o      (rel),
    .page_slot_o(page_slot)
  );

  assign s3_path = card_pg && (page_slot == INT_SLOT_ID) && !slot3_rom_i;

  slot_owner_track #(.SLOT_W(SLOT_W)) i_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe_i),
    .s3_path_i  (s3_path),
    .int_cx_i   (int_cx_i),
    .card_pg_i  (card_pg),
    .rel_i      (rel),
    .page_slot_i(page_slot),
    .owner_o    (owner),
    .int_exp_o  (int_exp)
  );

  slot_src_sel #(.SLOT_W(SLOT_W)) i_sel (
    .strobe_i   (strobe_i),
    .in_win_i   (in_win),
    .card_pg_i  (card_pg),
    .rel_i      (rel),
    .s3_path_i  (s3_path),
    .int_cx_i   (int_cx_i),
    .page_slot_i(page_slot),
    .owner_i    (owner),
    .int_exp_i  (int_exp),
    .src_o      (src),
    .slot_o     (slot_o)
  );

  assign src_o = src;

  a_r8_idle_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |-> (src_o == SRC_NONE) && (slot_o == '0));
  a_r5_release_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && addr_i == 16'hCFFF && !int_cx_i) |-> (src_o == SRC_EXP) && (slot_o == '0));
  a_r3_cx_internal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && in_win && int_cx_i) |-> (src_o == SRC_INT));
  a_r2_slot3_internal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && addr_i[15:8] == 8'hC3 && !slot3_rom_i) |-> (src_o == SRC_INT));
  a_r6_hidden_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && int_exp && addr_i[15:11] == 5'b11001 && addr_i != 16'hCFFF && !int_cx_i)
      |-> (src_o == SRC_INT));
endmodule

// File: tb/test_slot_rom_arbiter.sv
module test_slot_rom_arbiter;
  localparam int S_NONE = 0, S_INT = 1, S_CARD = 2, S_EXP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        strobe = 1'b0;
  logic        s3 = 1'b1;
  logic        cx = 1'b0;
  logic [1:0]  src;
  logic [2:0]  slot;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  slot_rom_arbiter i_slot_rom_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .strobe_i(strobe),
    .slot3_rom_i(s3), .int_cx_i(cx), .src_o(src), .slot_o(slot)
  );

  task automatic chk(string tag, int exp_src, int exp_slot);
    checks++;
    if (int'(src) != exp_src || int'(slot) != exp_slot) begin
      fails++;
      $display("FAIL %s src=%0d slot=%0d expected src=%0d slot=%0d", tag, src, slot, exp_src, exp_slot);
    end
  endtask

  task automatic acc(string tag, logic [15:0] a, logic stb, logic f3, logic fcx,
                     int exp_src, int exp_slot);
    @(negedge clk);
    addr = a; strobe = stb; s3 = f3; cx = fcx;
    #2 chk(tag, exp_src, exp_slot);
  endtask

  task automatic idle();
    @(negedge clk);
    strobe = 1'b0; s3 = 1'b1; cx = 1'b0;
  endtask

  task automatic t_reset();
    acc("R8 strobe low after reset", 16'hC500, 0, 1, 0, S_NONE, 0);
    acc("R7 owner cleared by reset", 16'hC800, 1, 1, 0, S_EXP, 0);
    acc("R7 hidden clear after reset", 16'hCC00, 1, 1, 0, S_EXP, 0);
  endtask

  task automatic t_card();
    acc("R1 card page slot 5", 16'hC534, 1, 1, 0, S_CARD, 5);
    acc("R4 R9 owner 5 next access", 16'hC800, 1, 1, 0, S_EXP, 5);
    acc("R4 owner 5 high exp addr", 16'hCA12, 1, 1, 0, S_EXP, 5);
    acc("R1 card page slot 1", 16'hC1FF, 1, 1, 0, S_CARD, 1);
    acc("R4 owner moves to 1", 16'hCFFE, 1, 1, 0, S_EXP, 1);
    idle();
  endtask

  task automatic t_ignored();
    acc("R8 strobe low C600", 16'hC600, 0, 1, 0, S_NONE, 0);
    acc("R8 owner unchanged after idle", 16'hC900, 1, 1, 0, S_EXP, 1);
    acc("R8 io page outside", 16'hC0FF, 1, 1, 0, S_NONE, 0);
    acc("R8 above window", 16'hD000, 1, 1, 0, S_NONE, 0);
    acc("R8 low memory", 16'h0C80, 1, 1, 0, S_NONE, 0);
    acc("R8 strobe low CFFF no release", 16'hCFFF, 0, 1, 0, S_NONE, 0);
    acc("R8 owner kept after outside", 16'hC800, 1, 1, 0, S_EXP, 1);
    idle();
  endtask

  task automatic t_slot3();
    acc("R2 slot3 internal", 16'hC310, 1, 0, 0, S_INT, 0);
    acc("R6 R10 hidden routes exp internal", 16'hC800, 1, 1, 0, S_INT, 0);
    acc("R6 hidden CFFE internal", 16'hCFFE, 1, 1, 0, S_INT, 0);
    acc("R1 slot3 card when enabled", 16'hC310, 1, 1, 0, S_CARD, 3);
    acc("R4 card clears hidden", 16'hC800, 1, 1, 0, S_EXP, 3);
    idle();
  endtask

  task automatic t_release();
    acc("R1 card slot 7", 16'hC700, 1, 1, 0, S_CARD, 7);
    acc("R9 owner 7 before release", 16'hC900, 1, 1, 0, S_EXP, 7);
    acc("R5 release same access", 16'hCFFF, 1, 1, 0, S_EXP, 0);
    acc("R5 owner 0 after release", 16'hC800, 1, 1, 0, S_EXP, 0);
    acc("R2 set hidden again", 16'hC3A0, 1, 0, 0, S_INT, 0);
    acc("R5 release overrides hidden", 16'hCFFF, 1, 1, 0, S_EXP, 0);
    acc("R5 hidden cleared by release", 16'hC800, 1, 1, 0, S_EXP, 0);
    idle();
  endtask

  task automatic t_intcx();
    acc("R1 card slot 2", 16'hC200, 1, 1, 0, S_CARD, 2);
    acc("R3 forced card page", 16'hC400, 1, 1, 1, S_INT, 0);
    acc("R3 forced release addr", 16'hCFFF, 1, 1, 1, S_INT, 0);
    acc("R3 forced exp", 16'hC800, 1, 1, 1, S_INT, 0);
    acc("R3 owner untouched", 16'hC800, 1, 1, 0, S_EXP, 2);
    acc("R2 slot3 priority over force", 16'hC300, 1, 0, 1, S_INT, 0);
    acc("R2 hidden set under force", 16'hC800, 1, 1, 0, S_INT, 0);
    acc("R3 forced card keeps hidden", 16'hC600, 1, 1, 1, S_INT, 0);
    acc("R3 hidden still set", 16'hC900, 1, 1, 0, S_INT, 0);
    acc("R5 release clears", 16'hCFFF, 1, 1, 0, S_EXP, 0);
    idle();
  endtask

  task automatic t_midreset();
    acc("R1 card slot 6", 16'hC6AB, 1, 1, 0, S_CARD, 6);
    acc("R2 set hidden", 16'hC301, 1, 0, 0, S_INT, 0);
    idle();
    rst_n = 1'b0;
    #3;
    acc("R8 R7 outputs idle in reset", 16'hC800, 0, 1, 0, S_NONE, 0);
    rst_n = 1'b1;
    acc("R7 state cleared mid run", 16'hC800, 1, 1, 0, S_EXP, 0);
    idle();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_card();
        t_ignored();
        t_slot3();
        t_release();
        t_intcx();
        t_midreset();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++;
          fails++;
          $display("FAIL watchdog expired");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule